// File: doc/BRIEF.md
# Flash Block Erase-and-Verify Sequencer

This block steps a flash array through erasing one block and then proving that the block reads back as all ones. It drives the array's control bits: an unlock bit that allows modification, an erase-setup bit, the erase pulse bit and an erase-check (verify) bit. It also drives a one-hot block select, a watchdog enable that is held only around the erase pulse, and a word address, write data and read/write strobes into the array. Each step is followed by a settle time. Every settle time comes from its own configuration input and is counted by one shared down-counter.

A request gives a block index, the first and last word address of the block and the largest number of erase attempts allowed. After every erase pass the block is scanned one word at a time. Each word gets a dummy write of all ones, a settle time and then a read. One word that is not all ones ends the scan. The block is then erased again, or the operation ends in failure once the attempts are used up. A request that names a block the array does not have is refused at once and flagged. Only one block is erased per request, and the block is not programmed to zeros first.

Top module: `blk_erase_seq`

## Requirements
- R1: After synchronous reset, every output is 0: all control bits, `blk_sel`, both strobes, `busy`, `done`, `fail` and `illegal`.
- R2: A `start` seen while idle with `blk_idx` < NUM_BLOCKS raises `busy`. Then `flash_unlock` alone is high for `t_unlock`+1 cycles. After that `blk_sel` carries only bit `blk_idx` for the rest of the operation, and it rises one cycle before `wdog_en`.
- R3: Each erase pass runs in this order. `wdog_en` rises for 1 cycle. `erase_setup` is then added for `t_setup`+1 cycles. `erase_pulse` is then added for `t_pulse`+1 cycles. `erase_pulse` is dropped for `t_hold`+1 cycles. `erase_setup` is dropped for `t_release`+1 cycles. `wdog_en` is dropped for 1 cycle.
- R4: Next, `erase_chk` rises and stays high for `t_chk_entry`+1 cycles plus `t_read`+4 cycles per word examined. Words are examined from `blk_first` upward in steps of 1. Each word gets one `fl_we` cycle with `fl_wdata` all ones, then `t_read`+1 cycles, then one `fl_re` cycle. The data returned one cycle after `fl_re` is tested.
- R5: When every word up to and including `blk_last` reads all ones, `erase_chk` drops and the unlock and select stay high for `t_exit`+1 cycles. All control bits then go low, `done` becomes 1 and `busy` then falls.
- R6: A word with any 0 bit ends the scan at that word. `erase_chk` drops for `t_exit`+1 cycles. If attempts remain, the next pass starts again at the watchdog step of R3, with `flash_unlock` held and no repeat of the unlock wait.
- R7: The attempt count starts at 1 for the first pass. At most `max_tries` passes run. If the last allowed pass also fails verify, all control bits go low and `fail` becomes 1 instead of `done`.
- R8: A `start` seen while idle with `blk_idx` >= NUM_BLOCKS sets `illegal` on the next cycle. It drives no control bit and no strobe, and `busy` stays 0.
- R9: A `start` seen while `busy` is 1 is ignored. The running operation, its selected block and its timing do not change.
- R10: A settle-time input of 0 gives a wait of exactly one cycle.
- R11: `done`, `fail` and `illegal` hold their value until the next `start` seen while idle, which clears all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse |
| blk_idx | input | IDX_W | Requested block index |
| blk_first | input | ADDR_W | First word address of the block |
| blk_last | input | ADDR_W | Last word address of the block |
| max_tries | input | CNT_W | Largest number of erase passes |
| t_unlock | input | DLY_W | Wait after unlock |
| t_setup | input | DLY_W | Wait after erase setup |
| t_pulse | input | DLY_W | Erase pulse length |
| t_hold | input | DLY_W | Wait after the pulse ends |
| t_release | input | DLY_W | Wait after setup is dropped |
| t_chk_entry | input | DLY_W | Wait after entering verify |
| t_read | input | DLY_W | Wait between dummy write and read |
| t_exit | input | DLY_W | Wait after leaving verify |
| fl_rdata | input | DATA_W | Read data from the array |
| fl_addr | output | ADDR_W | Word address to the array |
| fl_wdata | output | DATA_W | Dummy write data (all ones) |
| fl_we | output | 1 | Dummy write strobe |
| fl_re | output | 1 | Read strobe |
| flash_unlock | output | 1 | Modification enable |
| erase_setup | output | 1 | Erase setup bit |
| erase_pulse | output | 1 | Erase bit |
| erase_chk | output | 1 | Erase-verify bit |
| blk_sel | output | NUM_BLOCKS | One-hot block select |
| wdog_en | output | 1 | Watchdog enable |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last operation erased the block |
| fail | output | 1 | Last operation ran out of attempts |
| illegal | output | 1 | Last request named a missing block |

## Verification
Two decisions can fall in the same cycle. When the failing word is the block's last address, the end-of-scan test and the bad-word test both apply, and the bad word must win and cause a re-erase rather than success. On the final allowed pass the same bad word also coincides with the attempt limit. The bench provokes both cases by placing the array model's stubborn word at `blk_last` and needing more pulses than `max_tries` allows. It judges the result from the full trace of control phases and write addresses, the count of erase pulses and the final `fail`/`done` pair.

// File: rtl/ers_pkg.sv
package ers_pkg;
  typedef enum logic [4:0] {
    S_IDLE, S_UNLK, S_SEL, S_WDG, S_SET, S_PUL, S_HOLD, S_REL, S_WOFF,
    S_CHK, S_VWR, S_VWT, S_VRD, S_VCK, S_XOK, S_XBAD, S_FOK, S_FBAD
  } st_t;

  // control word {unlock, select, wdog, setup, pulse, chk}
  function automatic logic [5:0] ctrl_of(st_t s);
    case (s)
      S_UNLK:                       return 6'b100000;
      S_SEL, S_WOFF, S_XOK, S_XBAD: return 6'b110000;
      S_WDG, S_REL:                 return 6'b111000;
      S_SET, S_HOLD:                return 6'b111100;
      S_PUL:                        return 6'b111110;
      S_CHK, S_VWR, S_VWT,
      S_VRD, S_VCK:                 return 6'b110001;
      default:                      return 6'b000000;
    endcase
  endfunction
endpackage

// File: rtl/ers_timer.sv
module ers_timer #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  output logic             expired
);
  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R10: a loaded count reaches zero by stepping down one per cycle
  assert_step_down_R10: assert property (@(posedge clk) disable iff (rst)
    (!load && !expired) |=> (cnt < $past(cnt)));
endmodule

// File: rtl/ers_tries.sv
module ers_tries #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] limit,
  output logic             retry_ok
);
  logic [CNT_W-1:0] n;

  always_ff @(posedge clk) begin
    if (rst)      n <= '0;
    else if (clr) n <= CNT_W'(1);
    else if (inc) n <= n + 1'b1;
  end

  assign retry_ok = (n < limit);

  // R7: the pass count never goes past the allowed number of passes
  assert_try_bound_R7: assert property (@(posedge clk) disable iff (rst)
    inc |=> (n <= limit));
endmodule

// File: rtl/ers_scan.sv
module ers_scan #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] first,
  input  logic [ADDR_W-1:0] last,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] addr,
  output logic              at_last,
  output logic              word_ok
);
  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= first;
    else if (step) addr <= addr + 1'b1;
  end

  assign at_last = (addr == last);
  assign word_ok = &rdata;

  // R4: the scan never walks beyond the last word of the block
  assert_scan_bound_R4: assert property (@(posedge clk) disable iff (rst)
    step |-> !at_last);
endmodule

// File: rtl/blk_erase_seq.sv
module blk_erase_seq
  import ers_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int DLY_W      = 16,
  parameter int CNT_W      = 4,
  localparam int IDX_W     = $clog2(NUM_BLOCKS) + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [IDX_W-1:0]      blk_idx,
  input  logic [ADDR_W-1:0]     blk_first,
  input  logic [ADDR_W-1:0]     blk_last,
  input  logic [CNT_W-1:0]      max_tries,
  input  logic [DLY_W-1:0]      t_unlock,
  input  logic [DLY_W-1:0]      t_setup,
  input  logic [DLY_W-1:0]      t_pulse,
  input  logic [DLY_W-1:0]      t_hold,
  input  logic [DLY_W-1:0]      t_release,
  input  logic [DLY_W-1:0]      t_chk_entry,
  input  logic [DLY_W-1:0]      t_read,
  input  logic [DLY_W-1:0]      t_exit,
  input  logic [DATA_W-1:0]     fl_rdata,
  output logic [ADDR_W-1:0]     fl_addr,
  output logic [DATA_W-1:0]     fl_wdata,
  output logic                  fl_we,
  output logic                  fl_re,
  output logic                  flash_unlock,
  output logic                  erase_setup,
  output logic                  erase_pulse,
  output logic                  erase_chk,
  output logic [NUM_BLOCKS-1:0] blk_sel,
  output logic                  wdog_en,
  output logic                  busy,
  output logic                  done,
  output logic                  fail,
  output logic                  illegal
);
  st_t state, state_n;
  logic [IDX_W-1:0]      idx_q;
  logic [ADDR_W-1:0]     first_q, last_q;
  logic [CNT_W-1:0]      max_q;
  logic [DLY_W-1:0]      dly_n;
  logic [NUM_BLOCKS-1:0] sel_vec;
  logic [5:0]            ctrl_n;
  logic legal, tmr_zero, retry_ok, at_last, word_ok;
  logic ld_scan, step_scan, clr_try, inc_try;

  assign legal = (blk_idx < IDX_W'(NUM_BLOCKS));

  ers_timer #(.DLY_W(DLY_W)) u_timer (
    .clk(clk), .rst(rst), .load(state_n != state), .load_val(dly_n),
    .expired(tmr_zero));

  ers_tries #(.CNT_W(CNT_W)) u_tries (
    .clk(clk), .rst(rst), .clr(clr_try), .inc(inc_try), .limit(max_q),
    .retry_ok(retry_ok));

  ers_scan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_scan (
    .clk(clk), .rst(rst), .load(ld_scan), .step(step_scan),
    .first(first_q), .last(last_q), .rdata(fl_rdata), .addr(fl_addr),
    .at_last(at_last), .word_ok(word_ok));

  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_sel
    assign sel_vec[i] = (idx_q == IDX_W'(i));
  end

  always_comb begin
    state_n = state; ld_scan = 1'b0; step_scan = 1'b0;
    clr_try = 1'b0;  inc_try = 1'b0;
    case (state)
      S_IDLE: if (start && legal) begin state_n = S_UNLK; clr_try = 1'b1; end
      S_UNLK: if (tmr_zero) state_n = S_SEL;
      S_SEL:  state_n = S_WDG;
      S_WDG:  state_n = S_SET;
      S_SET:  if (tmr_zero) state_n = S_PUL;
      S_PUL:  if (tmr_zero) state_n = S_HOLD;
      S_HOLD: if (tmr_zero) state_n = S_REL;
      S_REL:  if (tmr_zero) state_n = S_WOFF;
      S_WOFF: begin state_n = S_CHK; ld_scan = 1'b1; end
      S_CHK:  if (tmr_zero) state_n = S_VWR;
      S_VWR:  state_n = S_VWT;
      S_VWT:  if (tmr_zero) state_n = S_VRD;
      S_VRD:  state_n = S_VCK;
      S_VCK: begin
        if (!word_ok)     state_n = S_XBAD;
        else if (at_last) state_n = S_XOK;
        else begin state_n = S_VWR; step_scan = 1'b1; end
      end
      S_XOK:  if (tmr_zero) state_n = S_FOK;
      S_XBAD: if (tmr_zero) begin
        if (retry_ok) begin state_n = S_WDG; inc_try = 1'b1; end
        else state_n = S_FBAD;
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_comb begin
    case (state_n)
      S_UNLK:  dly_n = t_unlock;
      S_SET:   dly_n = t_setup;
      S_PUL:   dly_n = t_pulse;
      S_HOLD:  dly_n = t_hold;
      S_REL:   dly_n = t_release;
      S_CHK:   dly_n = t_chk_entry;
      S_VWT:   dly_n = t_read;
      S_XOK, S_XBAD: dly_n = t_exit;
      default: dly_n = '0;
    endcase
  end

  assign ctrl_n   = ctrl_of(state_n);
  assign fl_wdata = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; idx_q <= '0; first_q <= '0; last_q <= '0; max_q <= '0;
      {flash_unlock, erase_setup, erase_pulse, erase_chk, wdog_en} <= '0;
      blk_sel <= '0; fl_we <= 1'b0; fl_re <= 1'b0; busy <= 1'b0;
      done <= 1'b0; fail <= 1'b0; illegal <= 1'b0;
    end else begin
      state        <= state_n;
      flash_unlock <= ctrl_n[5];
      blk_sel      <= ctrl_n[4] ? sel_vec : '0;
      wdog_en      <= ctrl_n[3];
      erase_setup  <= ctrl_n[2];
      erase_pulse  <= ctrl_n[1];
      erase_chk    <= ctrl_n[0];
      fl_we        <= (state_n == S_VWR);
      fl_re        <= (state_n == S_VRD);
      busy         <= (state_n != S_IDLE);
      if (state == S_IDLE && start) begin
        done <= 1'b0; fail <= 1'b0; illegal <= !legal;
        idx_q <= blk_idx; first_q <= blk_first; last_q <= blk_last;
        max_q <= max_tries;
      end
      if (state_n == S_FOK)  done <= 1'b1;
      if (state_n == S_FBAD) fail <= 1'b1;
    end
  end

  // R2: the select never carries more than one bit
  assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(blk_sel));
  // R2: unlock comes first, before any other control bit
  assert_unlock_first_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(flash_unlock) |-> (blk_sel == '0 && !erase_setup && !erase_chk));
  // R3: the pulse only runs with setup, watchdog, unlock and one block
  assert_pulse_guard_R3: assert property (@(posedge clk) disable iff (rst)
    erase_pulse |-> (erase_setup && wdog_en && flash_unlock && $onehot(blk_sel)));
  // R3: the pulse rises only after setup was already high
  assert_setup_before_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(erase_pulse) |-> $past(erase_setup));
  // R4: verify never overlaps the erase bits or the watchdog
  assert_verify_excl_R4: assert property (@(posedge clk) disable iff (rst)
    erase_chk |-> (!erase_setup && !erase_pulse && !wdog_en));
  // R4: strobes happen only inside verify
  assert_strobe_in_verify_R4: assert property (@(posedge clk) disable iff (rst)
    (fl_we || fl_re) |-> erase_chk);
  // R5: success and failure are never reported together
  assert_status_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(done && fail));
  // R8: a refused request leaves the sequencer quiet
  assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!busy && !flash_unlock && blk_sel == '0));
endmodule

// File: tb/test_blk_erase_seq.sv
module test_blk_erase_seq;
  localparam int NB = 8, AW = 16, DW = 16, TW = 16, CW = 4;
  localparam int IW = $clog2(NB) + 1;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [IW-1:0] blk_idx = '0;
  logic [AW-1:0] blk_first = '0, blk_last = '0;
  logic [CW-1:0] max_tries = '0;
  logic [TW-1:0] t_unlock = '0, t_setup = '0, t_pulse = '0, t_hold = '0;
  logic [TW-1:0] t_release = '0, t_chk_entry = '0, t_read = '0, t_exit = '0;
  logic [DW-1:0] fl_rdata;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata;
  logic fl_we, fl_re, flash_unlock, erase_setup, erase_pulse, erase_chk;
  logic [NB-1:0] blk_sel;
  logic wdog_en, busy, done, fail, illegal;

  blk_erase_seq #(.NUM_BLOCKS(NB), .ADDR_W(AW), .DATA_W(DW), .DLY_W(TW),
                  .CNT_W(CW)) i_blk_erase_seq (.*);

  always #5 clk = ~clk;

  // behavioural array: a stubborn word clears only after enough pulses
  logic model_clr = 1'b0, pulse_q;
  int   pulses, need_pulses;
  logic [AW-1:0] bad_addr;
  always_ff @(posedge clk) begin
    pulse_q <= erase_pulse;
    if (model_clr) pulses <= 0;
    else if (erase_pulse && !pulse_q) pulses <= pulses + 1;
    if (fl_re)
      fl_rdata <= (pulses < need_pulses && fl_addr == bad_addr) ? 16'hFEFF : 16'hFFFF;
  end

  logic [5:0] ctrl;
  assign ctrl = {flash_unlock, |blk_sel, wdog_en, erase_setup, erase_pulse, erase_chk};

  int nchk = 0, nfail = 0;
  logic [5:0] g_val[64], e_val[64];
  int g_len[64], e_len[64], g_n, e_n;
  int w_addr[64], x_addr[64], w_n, x_n;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push_e(logic [5:0] v, int l);
    if (e_n < 64) begin e_val[e_n] = v; e_len[e_n] = l; end
    e_n++;
  endtask

  task automatic set_dly(int x, int y, int z, int a, int b, int g, int e, int h);
    t_unlock = TW'(x); t_setup = TW'(y); t_pulse = TW'(z); t_hold = TW'(a);
    t_release = TW'(b); t_chk_entry = TW'(g); t_read = TW'(e); t_exit = TW'(h);
  endtask

  // one erase request; badoff is the stubborn word's offset, need the pulses to clear it
  task automatic run_op(string req, int idx, int first, int nwords, int maxt,
                        int need, int badoff, bit inject);
    int attempts, cyc, bad_ph, sel_bad, wd_bad;
    bit ok_end, ok;
    blk_idx = IW'(idx); blk_first = AW'(first); blk_last = AW'(first + nwords - 1);
    max_tries = CW'(maxt); need_pulses = need;
    bad_addr = (badoff < 0) ? 16'hFFFF : AW'(first + badoff);
    @(negedge clk) model_clr = 1'b1;
    @(negedge clk) model_clr = 1'b0; start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(!done && !fail && !illegal && busy, "R11", "status cleared on start", int'(done), 0);
    g_n = 0; w_n = 0; cyc = 0; sel_bad = 0; wd_bad = 0;
    while (busy && cyc < 5000) begin
      if (g_n > 0 && g_val[g_n-1] == ctrl) g_len[g_n-1]++;
      else begin
        if (g_n < 64) begin g_val[g_n] = ctrl; g_len[g_n] = 1; end
        g_n++;
      end
      if (blk_sel != '0 && blk_sel != NB'(1 << idx)) sel_bad++;
      if (fl_we) begin
        if (w_n < 64) w_addr[w_n] = int'(fl_addr);
        w_n++;
        if (fl_wdata != '1) wd_bad++;
      end
      if (inject && cyc == 4) begin start = 1'b1; blk_idx = IW'((idx + 1) % NB); end
      if (inject && cyc == 5) start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    // expected trace from the requirements
    ok_end = (need <= maxt);
    attempts = ok_end ? ((need < 1) ? 1 : need) : maxt;
    e_n = 0; x_n = 0;
    for (int a = 1; a <= attempts; a++) begin
      bit last_ok = ok_end && (a == attempts);
      int words = last_ok ? nwords : badoff + 1;
      if (a == 1) begin
        push_e(6'b100000, int'(t_unlock) + 1);
        push_e(6'b110000, 1);
      end
      push_e(6'b111000, 1);
      push_e(6'b111100, int'(t_setup) + 1);
      push_e(6'b111110, int'(t_pulse) + 1);
      push_e(6'b111100, int'(t_hold) + 1);
      push_e(6'b111000, int'(t_release) + 1);
      push_e(6'b110000, 1);
      push_e(6'b110001, int'(t_chk_entry) + 1 + words * (int'(t_read) + 4));
      push_e(6'b110000, int'(t_exit) + 1);
      for (int k = 0; k < words; k++) begin
        if (x_n < 64) x_addr[x_n] = first + k;
        x_n++;
      end
    end
    push_e(6'b000000, 1);
    ok = (g_n == e_n); bad_ph = -1;
    for (int i = 0; i < e_n && i < 64 && i < g_n; i++)
      if (ok && (g_val[i] != e_val[i] || g_len[i] != e_len[i])) begin ok = 0; bad_ph = i; end
    if (bad_ph >= 0)
      chk(0, req, "control phase length", g_len[bad_ph], e_len[bad_ph]);
    else chk(ok, req, "control phase count", g_n, e_n);
    ok = (w_n == x_n);
    for (int i = 0; i < x_n && i < 64; i++) if (ok && w_addr[i] != x_addr[i]) ok = 0;
    chk(ok, "R4", "dummy write address sequence", w_n, x_n);
    chk(wd_bad == 0, "R4", "dummy write data not all ones", wd_bad, 0);
    chk(sel_bad == 0, "R2", "block select value", sel_bad, 0);
    chk(pulses == attempts, (ok_end ? "R6" : "R7"), "erase pulses", pulses, attempts);
    chk(done == ok_end && fail == !ok_end && ctrl == 6'b0, (ok_end ? "R5" : "R7"),
        "final done", int'(done), int'(ok_end));
  endtask

  task automatic t_reset;
    chk(ctrl == 0 && blk_sel == 0 && !fl_we && !fl_re && !busy && !done && !fail && !illegal,
        "R1", "outputs after reset", int'(ctrl), 0);
  endtask

  task automatic t_illegal;
    blk_idx = IW'(NB); start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(illegal && !done, "R8", "illegal flag and cleared done", int'(illegal), 1);
    repeat (3) @(negedge clk);
    chk(!busy && ctrl == 0 && !fl_we && !fl_re, "R8", "no control activity",
        int'(ctrl), 0);
    chk(illegal, "R11", "illegal held", int'(illegal), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    set_dly(3, 2, 5, 1, 2, 3, 1, 2);
    run_op("R3", 3, 16, 4, 3, 1, -1, 1'b0);   // first pass succeeds
    run_op("R6", 5, 32, 4, 3, 2, 2, 1'b0);    // one re-erase needed
    run_op("R7", 0, 48, 3, 3, 9, 2, 1'b0);    // stubborn last word, limit reached
    t_illegal();
    set_dly(0, 0, 0, 0, 0, 0, 0, 0);
    run_op("R10", 7, 100, 1, 2, 1, -1, 1'b0); // all one-cycle waits
    set_dly(2, 1, 3, 2, 1, 2, 2, 1);
    run_op("R9", 2, 200, 3, 2, 1, -1, 1'b1);  // start while busy ignored
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule